// File: doc/BRIEF.md
# Framed Serial Word Receiver

This block takes a serial bit stream and turns it into parallel data words. A data line and a frame-sync line are sampled on each rising edge of a serial bit clock, and that clock is oversampled by the system clock. A receive frame opens in one of two ways. In level-start mode a high sync bit opens the frame. In compare-start mode the receiver hunts the sync line until the most recent sync bits equal one of two programmed patterns. The sync bits that opened the frame are kept in a sync data register.

After the sync field, the receiver collects a programmed number of words per frame. The word length and the bit order are programmable. Each word is right-aligned in a 32-bit result, and the result carries a size code for a downstream DMA engine. A loopback mode feeds the receiver from the transmit-side data, sync and clock lines. Configuration arrives on plain input ports. The receiver copies it only while it is idle between frames.

The result leaves on a valid/ready stream without a queue. `out_valid` stays high until the consumer raises `out_ready`. The receiver cannot stall the serial line, so back-pressure cannot hold a word back. When a new word completes while the previous one is still unread, the new word replaces the old one and `overrun` pulses for one cycle.

Top module: `sser_rx`

## Requirements
- R1: A word holds `cfg_bits_m1`+1 bits, right-aligned in `out_data`; every bit above the word length reads zero.
- R2: `cfg_bits_m1`=0 (one-bit words) is illegal. `cfg_err` is high while it is applied, no frame starts, and no word is produced.
- R3: `out_size` encodes the word length. The code is 0 (byte) when `cfg_bits_m1`≤7, 1 (half-word) for 8..15, and 2 (32-bit) for 16 and above.
- R4: With `cfg_msb_first`=1 the first data bit received lands in bit `cfg_bits_m1` of `out_data`. With 0 it lands in bit 0, and later bits fill upward.
- R5: A frame delivers exactly `cfg_words_m1`+1 words and then returns to idle (`busy` low). Data bits after that produce no word until a new frame start.
- R6: Level-start mode (`cfg_cmp_start`=0): a sync bit of 1 sampled while idle opens the frame. That bit and the following sync bits, L=`cfg_sync_m1`+1 in all, are stored in `sync_data[L-1:0]` with the first one in bit L-1. Data starts on the next bit clock edge.
- R7: Compare-start mode (`cfg_cmp_start`=1): after at least L hunted sync bits, the frame opens when the last L sync bits (oldest in bit L-1) equal the low L bits of `cfg_cmp0` or `cfg_cmp1`. The matching bits go to `sync_data` and data starts on the next edge.
- R8: With `cfg_loop`=1 the receiver uses `tx_data`, `tx_sync` and `tx_sclk`, and ignores `rx_data`, `rx_sync` and `rx_sclk`.
- R9: `out_valid` stays high with `out_data` stable until `out_ready` is high. A word that completes while `out_valid` is high and `out_ready` is low replaces the held word and pulses `overrun` for one cycle.
- R10: Changes to bit order, word length or words per frame made after a frame opens do not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_data | input | 1 | Receive serial data |
| rx_sync | input | 1 | Receive frame sync |
| rx_sclk | input | 1 | Receive bit clock (sampled on rising edge) |
| tx_data | input | 1 | Transmit data, used in loopback |
| tx_sync | input | 1 | Transmit frame sync, used in loopback |
| tx_sclk | input | 1 | Transmit bit clock, used in loopback |
| cfg_loop | input | 1 | Loopback select |
| cfg_msb_first | input | 1 | Bit order: 1 = first bit is MSB |
| cfg_cmp_start | input | 1 | 0 = level start, 1 = compare start |
| cfg_bits_m1 | input | 5 | Word length minus one (0 illegal) |
| cfg_words_m1 | input | 4 | Words per frame minus one |
| cfg_sync_m1 | input | 4 | Sync field length minus one |
| cfg_cmp0 | input | 16 | First start pattern |
| cfg_cmp1 | input | 16 | Second start pattern |
| out_data | output | 32 | Received word, right-aligned |
| out_valid | output | 1 | Word available |
| out_ready | input | 1 | Consumer accepts word |
| out_size | output | 2 | DMA transfer size code |
| overrun | output | 1 | One-cycle pulse: unread word replaced |
| sync_data | output | 16 | Captured sync bits |
| busy | output | 1 | Frame in progress |
| cfg_err | output | 1 | Illegal word length applied |

## Verification
Assertions check several properties on every cycle: the held-word rule of the stream, that an overrun pulse comes only after an unaccepted word, that the zero upper bits agree with the size code, that the bit counter stays within the word length, and that an illegal length keeps the receiver idle. Other behaviours can only be shown by the bench's scenarios. These are the packing order, the word count per frame, the level and compare starts with their captured sync bits, loopback source selection, and the freezing of configuration mid-frame. The bench serialises known words and compares what comes out.

// File: rtl/sser_rx_pkg.sv
package sser_rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SYNC = 2'd1,
    ST_DATA = 2'd2
  } rx_state_e;

  typedef enum logic [1:0] {
    XS_BYTE = 2'd0,
    XS_HALF = 2'd1,
    XS_WORD = 2'd2
  } xfer_size_e;
endpackage

// File: rtl/sser_rx_front.sv
module sser_rx_front (
  input  logic clk,
  input  logic rst_n,
  input  logic loop_en,
  input  logic rx_d,
  input  logic rx_s,
  input  logic rx_c,
  input  logic tx_d,
  input  logic tx_s,
  input  logic tx_c,
  output logic bit_stb,
  output logic bit_d,
  output logic bit_s
);
  logic d_r, s_r, c_r, c_r2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_r  <= 1'b0;
      s_r  <= 1'b0;
      c_r  <= 1'b0;
      c_r2 <= 1'b0;
    end else begin
      d_r  <= loop_en ? tx_d : rx_d;
      s_r  <= loop_en ? tx_s : rx_s;
      c_r  <= loop_en ? tx_c : rx_c;
      c_r2 <= c_r;
    end
  end

  assign bit_stb = c_r & ~c_r2;
  assign bit_d   = d_r;
  assign bit_s   = s_r;

  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |=> !bit_stb); // R6
endmodule

// File: rtl/sser_rx_sync.sv
module sser_rx_sync #(
  parameter int SW = 16,
  localparam int SLW = $clog2(SW)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           shift,
  input  logic           load_first,
  input  logic           bit_s,
  input  logic [SLW-1:0] len_m1,
  input  logic [SW-1:0]  cmp0,
  input  logic [SW-1:0]  cmp1,
  output logic [SW-1:0]  win_shift,
  output logic [SW-1:0]  win_first,
  output logic           full_shift,
  output logic           full_first,
  output logic           match_shift
);
  logic [SW-1:0]  win;
  logic [SLW:0]   fill, fill_inc;
  logic [SW-1:0]  mask;
  logic [SW-1:0]  ones;

  assign ones      = '1;
  assign mask      = ones >> (SLW'(SW - 1) - len_m1);
  assign win_shift = {win[SW-2:0], bit_s} & mask;
  assign win_first = {{(SW-1){1'b0}}, bit_s};
  assign fill_inc  = (fill == (SLW+1)'(SW)) ? fill : fill + 1'b1;
  assign full_shift = fill_inc > {1'b0, len_m1};
  assign full_first = (len_m1 == '0);
  assign match_shift = full_shift &&
                       ((win_shift == (cmp0 & mask)) || (win_shift == (cmp1 & mask)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win  <= '0;
      fill <= '0;
    end else if (clr) begin
      win  <= '0;
      fill <= '0;
    end else if (load_first) begin
      win  <= win_first;
      fill <= (SLW+1)'(1);
    end else if (shift) begin
      win  <= win_shift;
      fill <= fill_inc;
    end
  end

  AST_FILL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= (SLW+1)'(SW)); // R7
endmodule

// File: rtl/sser_rx_pack.sv
module sser_rx_pack
  import sser_rx_pkg::*;
#(
  parameter int DW = 32,
  localparam int LW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_en,
  input  logic          bit_d,
  input  logic          msb_first,
  input  logic [LW-1:0] len_m1,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          out_valid,
  output logic [1:0]    out_size,
  output logic          overrun,
  output logic          word_done
);
  logic [DW-1:0] acc, acc_next;
  logic [LW-1:0] bcnt;

  function automatic logic [1:0] size_code(input logic [LW-1:0] n);
    if (n <= LW'(7))       return XS_BYTE;
    else if (n <= LW'(15)) return XS_HALF;
    else                   return XS_WORD;
  endfunction

  always_comb begin
    if (msb_first) acc_next = {acc[DW-2:0], bit_d};
    else           acc_next = acc | (DW'(bit_d) << bcnt);
  end

  assign word_done = bit_en && (bcnt == len_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc  <= '0;
      bcnt <= '0;
    end else if (bit_en) begin
      if (word_done) begin
        acc  <= '0;
        bcnt <= '0;
      end else begin
        acc  <= acc_next;
        bcnt <= bcnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data  <= '0;
      out_valid <= 1'b0;
      out_size  <= XS_BYTE;
      overrun   <= 1'b0;
    end else if (word_done) begin
      out_data  <= acc_next;
      out_valid <= 1'b1;
      out_size  <= size_code(len_m1);
      overrun   <= out_valid && !out_ready;
    end else begin
      overrun <= 1'b0;
      if (out_ready) out_valid <= 1'b0;
    end
  end

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid); // R9
  AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> $past(out_valid && !out_ready)); // R9
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_size == XS_WORD) ||
                  (out_size == XS_HALF && out_data[DW-1:16] == '0) ||
                  (out_size == XS_BYTE && out_data[DW-1:8] == '0)); // R1
  AST_BCNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en |-> bcnt <= len_m1); // R1
endmodule

// File: rtl/sser_rx.sv
module sser_rx
  import sser_rx_pkg::*;
#(
  parameter int DW  = 32,
  parameter int SW  = 16,
  parameter int NWW = 4,
  localparam int LW  = $clog2(DW),
  localparam int SLW = $clog2(SW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rx_data,
  input  logic            rx_sync,
  input  logic            rx_sclk,
  input  logic            tx_data,
  input  logic            tx_sync,
  input  logic            tx_sclk,
  input  logic            cfg_loop,
  input  logic            cfg_msb_first,
  input  logic            cfg_cmp_start,
  input  logic [LW-1:0]   cfg_bits_m1,
  input  logic [NWW-1:0]  cfg_words_m1,
  input  logic [SLW-1:0]  cfg_sync_m1,
  input  logic [SW-1:0]   cfg_cmp0,
  input  logic [SW-1:0]   cfg_cmp1,
  output logic [DW-1:0]   out_data,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [1:0]      out_size,
  output logic            overrun,
  output logic [SW-1:0]   sync_data,
  output logic            busy,
  output logic            cfg_err
);
  rx_state_e state, state_n;

  logic           sh_loop, sh_msb, sh_cmp;
  logic [LW-1:0]  sh_bits_m1;
  logic [NWW-1:0] sh_words_m1;
  logic [SLW-1:0] sh_sync_m1;
  logic [SW-1:0]  sh_cmp0, sh_cmp1;
  logic [NWW-1:0] wcnt;

  logic bit_stb, bit_d, bit_s;
  logic sy_clr, sy_shift, sy_first, sy_cap;
  logic [SW-1:0] win_shift, win_first;
  logic full_shift, full_first, match_shift;
  logic bit_en, word_done;

  sser_rx_front i_front (
    .clk(clk), .rst_n(rst_n), .loop_en(sh_loop),
    .rx_d(rx_data), .rx_s(rx_sync), .rx_c(rx_sclk),
    .tx_d(tx_data), .tx_s(tx_sync), .tx_c(tx_sclk),
    .bit_stb(bit_stb), .bit_d(bit_d), .bit_s(bit_s)
  );

  sser_rx_sync #(.SW(SW)) i_sync (
    .clk(clk), .rst_n(rst_n), .clr(sy_clr), .shift(sy_shift),
    .load_first(sy_first), .bit_s(bit_s), .len_m1(sh_sync_m1),
    .cmp0(sh_cmp0), .cmp1(sh_cmp1),
    .win_shift(win_shift), .win_first(win_first),
    .full_shift(full_shift), .full_first(full_first),
    .match_shift(match_shift)
  );

  sser_rx_pack #(.DW(DW)) i_pack (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_d(bit_d),
    .msb_first(sh_msb), .len_m1(sh_bits_m1), .out_ready(out_ready),
    .out_data(out_data), .out_valid(out_valid), .out_size(out_size),
    .overrun(overrun), .word_done(word_done)
  );

  assign cfg_err = (cfg_bits_m1 == '0);
  assign busy    = (state != ST_IDLE);

  always_comb begin
    state_n  = state;
    sy_clr   = 1'b0;
    sy_shift = 1'b0;
    sy_first = 1'b0;
    sy_cap   = 1'b0;
    bit_en   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (bit_stb && sh_bits_m1 != '0) begin
          if (sh_cmp) begin
            sy_shift = 1'b1;
            if (match_shift) begin
              sy_cap  = 1'b1;
              state_n = ST_DATA;
            end
          end else if (bit_s) begin
            sy_first = 1'b1;
            if (full_first) begin
              sy_cap  = 1'b1;
              state_n = ST_DATA;
            end else begin
              state_n = ST_SYNC;
            end
          end
        end
      end
      ST_SYNC: begin
        if (bit_stb) begin
          sy_shift = 1'b1;
          if (full_shift) begin
            sy_cap  = 1'b1;
            state_n = ST_DATA;
          end
        end
      end
      ST_DATA: begin
        bit_en = bit_stb;
        if (word_done && wcnt == sh_words_m1) begin
          sy_clr  = 1'b1;
          state_n = ST_IDLE;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      wcnt      <= '0;
      sync_data <= '0;
    end else begin
      state <= state_n;
      if (sy_cap) sync_data <= sy_first ? win_first : win_shift;
      if (state == ST_DATA && word_done) begin
        if (wcnt == sh_words_m1) wcnt <= '0;
        else                     wcnt <= wcnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_loop     <= 1'b0;
      sh_msb      <= 1'b0;
      sh_cmp      <= 1'b0;
      sh_bits_m1  <= '0;
      sh_words_m1 <= '0;
      sh_sync_m1  <= '0;
      sh_cmp0     <= '0;
      sh_cmp1     <= '0;
    end else if (state == ST_IDLE && state_n == ST_IDLE) begin
      sh_loop     <= cfg_loop;
      sh_msb      <= cfg_msb_first;
      sh_cmp      <= cfg_cmp_start;
      sh_bits_m1  <= cfg_bits_m1;
      sh_words_m1 <= cfg_words_m1;
      sh_sync_m1  <= cfg_sync_m1;
      sh_cmp0     <= cfg_cmp0;
      sh_cmp1     <= cfg_cmp1;
    end
  end

  AST_ILLEGAL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && sh_bits_m1 == '0) |=> state == ST_IDLE); // R2
  AST_WORD_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(state == ST_DATA)); // R5
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA && $past(state) == ST_DATA) |-> $stable(sh_bits_m1)); // R10
endmodule

// File: tb/test_sser_rx.sv
module test_sser_rx;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_data = 0, rx_sync = 0, rx_sclk = 0;
  logic tx_data = 0, tx_sync = 0, tx_sclk = 0;
  logic cfg_loop = 0, cfg_msb_first = 0, cfg_cmp_start = 0;
  logic [4:0]  cfg_bits_m1 = 5'd7;
  logic [3:0]  cfg_words_m1 = 4'd0;
  logic [3:0]  cfg_sync_m1 = 4'd0;
  logic [15:0] cfg_cmp0 = 16'h0, cfg_cmp1 = 16'h0;
  logic [31:0] out_data;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [1:0]  out_size;
  logic        overrun;
  logic [15:0] sync_data;
  logic        busy, cfg_err;

  int checks = 0;
  int failures = 0;
  int ovr_cnt = 0;
  bit use_tx = 0;
  logic [31:0] got_d[$];
  logic [1:0]  got_s[$];
  logic [31:0] exp_d[16];

  sser_rx i_sser_rx (
    .clk(clk), .rst_n(rst_n),
    .rx_data(rx_data), .rx_sync(rx_sync), .rx_sclk(rx_sclk),
    .tx_data(tx_data), .tx_sync(tx_sync), .tx_sclk(tx_sclk),
    .cfg_loop(cfg_loop), .cfg_msb_first(cfg_msb_first), .cfg_cmp_start(cfg_cmp_start),
    .cfg_bits_m1(cfg_bits_m1), .cfg_words_m1(cfg_words_m1), .cfg_sync_m1(cfg_sync_m1),
    .cfg_cmp0(cfg_cmp0), .cfg_cmp1(cfg_cmp1),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_size(out_size), .overrun(overrun), .sync_data(sync_data),
    .busy(busy), .cfg_err(cfg_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid && out_ready) begin
        got_d.push_back(out_data);
        got_s.push_back(out_size);
      end
      if (overrun) ovr_cnt++;
    end
  end

  function automatic logic [1:0] exp_size(input int len_m1);
    if (len_m1 <= 7) return 2'd0;
    if (len_m1 <= 15) return 2'd1;
    return 2'd2;
  endfunction

  function automatic logic [31:0] low_mask(input int nbits);
    return (nbits >= 32) ? 32'hFFFF_FFFF : ((32'd1 << nbits) - 32'd1);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic d, input logic s, input logic sc, input logic gc);
    if (use_tx) begin
      tx_data = d;  tx_sync = s;    tx_sclk = sc;
      rx_data = ~d; rx_sync = 1'b1; rx_sclk = gc;
    end else begin
      rx_data = d;  rx_sync = s;    rx_sclk = sc;
      tx_data = ~d; tx_sync = 1'b1; tx_sclk = gc;
    end
  endtask

  task automatic put_bit(input logic d, input logic s);
    @(negedge clk);
    drive(d, s, 1'b0, 1'b1);
    @(negedge clk);
    @(negedge clk);
    drive(d, s, 1'b1, 1'b0);
    @(negedge clk);
  endtask

  task automatic idle_wait(input int n);
    @(negedge clk);
    rx_sclk = 1'b0; tx_sclk = 1'b0; rx_sync = 1'b0; tx_sync = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic run_frame(input bit cmp_mode, input bit msb, input int len_m1,
                           input int words_m1, input int sl_m1, input bit loop,
                           input bit mid_change, input bit hold);
    int L;
    logic [15:0] pat, other;
    string tag;
    L = sl_m1 + 1;
    pat   = 16'(($urandom & low_mask(L)) | (32'd1 << (L - 1)));
    other = 16'(($urandom & low_mask(L)) | (32'd1 << (L - 1)));
    idle_wait(1);
    cfg_loop = loop; cfg_msb_first = msb; cfg_cmp_start = cmp_mode;
    cfg_bits_m1 = 5'(len_m1); cfg_words_m1 = 4'(words_m1); cfg_sync_m1 = 4'(sl_m1);
    if ($urandom % 2 == 0) begin cfg_cmp0 = pat; cfg_cmp1 = other; end
    else                   begin cfg_cmp0 = other; cfg_cmp1 = pat; end
    use_tx = loop;
    out_ready = !hold;
    idle_wait(4);
    got_d.delete(); got_s.delete(); ovr_cnt = 0;
    if (cmp_mode) for (int i = 0; i < L; i++) put_bit(1'($urandom), 1'b0);
    else          for (int i = 0; i < 2; i++) put_bit(1'($urandom), 1'b0);
    for (int i = L - 1; i >= 0; i--) put_bit(1'($urandom), pat[i]);
    if (mid_change) begin
      cfg_msb_first = ~msb;
      cfg_bits_m1   = 5'($urandom_range(31, 1));
      cfg_words_m1  = 4'($urandom_range(3, 0));
    end
    for (int w = 0; w <= words_m1; w++) begin
      exp_d[w] = $urandom & low_mask(len_m1 + 1);
      for (int b = 0; b <= len_m1; b++)
        put_bit(exp_d[w][msb ? (len_m1 - b) : b], 1'b0);
    end
    put_bit(1'b1, 1'b0);
    put_bit(1'b1, 1'b0);
    idle_wait(6);
    tag = $sformatf("%s%s%s", msb ? "R4 " : "R1 ", loop ? "R8 " : "", mid_change ? "R10 " : "");
    if (hold) begin
      chk(out_valid == 1'b1, "R9 valid held", 32'(out_valid), 32'd1);
      chk(out_data == exp_d[words_m1], "R9 newest word kept", out_data, exp_d[words_m1]);
      chk(ovr_cnt == words_m1, "R9 overrun pulses", 32'(ovr_cnt), 32'(words_m1));
      chk(got_d.size() == 0, "R9 nothing taken", 32'(got_d.size()), 32'd0);
      out_ready = 1'b1;
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0, "R9 valid drops after ready", 32'(out_valid), 32'd0);
      chk(got_d.size() == 1, "R9 one handshake", 32'(got_d.size()), 32'd1);
    end else begin
      chk(got_d.size() == words_m1 + 1, "R5 words per frame", 32'(got_d.size()), 32'(words_m1 + 1));
      for (int w = 0; w <= words_m1 && w < got_d.size(); w++) begin
        chk(got_d[w] == exp_d[w], {tag, "word data"}, got_d[w], exp_d[w]);
        chk(got_s[w] == exp_size(len_m1), "R3 size code", 32'(got_s[w]), 32'(exp_size(len_m1)));
      end
      chk(ovr_cnt == 0, "R9 no overrun when ready", 32'(ovr_cnt), 32'd0);
    end
    chk(sync_data == pat, cmp_mode ? "R7 sync capture" : "R6 sync capture", 32'(sync_data), 32'(pat));
    chk(busy == 1'b0, "R5 idle after frame", 32'(busy), 32'd0);
  endtask

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0 && overrun == 1'b0, "R9 reset outputs", {30'd0, out_valid, overrun}, 32'd0);
    chk(busy == 1'b0 && sync_data == 16'h0, "R5 reset idle", {15'd0, busy, sync_data}, 32'd0);

    run_frame(0, 1, 7,  1, 0,  0, 0, 0);
    run_frame(0, 0, 8,  0, 15, 0, 0, 0);
    run_frame(1, 1, 15, 2, 3,  0, 0, 0);
    run_frame(1, 0, 16, 0, 15, 0, 0, 0);
    run_frame(1, 1, 31, 1, 0,  0, 0, 0);
    run_frame(0, 0, 1,  3, 5,  1, 0, 0);
    run_frame(1, 1, 12, 1, 7,  1, 0, 0);
    run_frame(0, 1, 10, 2, 2,  0, 1, 0);
    run_frame(0, 1, 7,  1, 0,  0, 0, 1);
    run_frame(1, 0, 5,  2, 4,  0, 0, 1);

    // R2: illegal one-bit word length
    idle_wait(1);
    cfg_bits_m1 = 5'd0; cfg_cmp_start = 1'b0; cfg_loop = 1'b0; use_tx = 0;
    idle_wait(4);
    got_d.delete();
    chk(cfg_err == 1'b1, "R2 cfg_err raised", 32'(cfg_err), 32'd1);
    for (int i = 0; i < 12; i++) put_bit(1'($urandom), 1'b1);
    idle_wait(6);
    chk(got_d.size() == 0 && out_valid == 1'b0, "R2 no word", 32'(got_d.size()), 32'd0);
    chk(busy == 1'b0, "R2 stays idle", 32'(busy), 32'd0);
    cfg_bits_m1 = 5'd3;
    @(negedge clk);
    chk(cfg_err == 1'b0, "R2 cfg_err clear", 32'(cfg_err), 32'd0);

    for (int n = 0; n < 40; n++)
      run_frame(1'($urandom), 1'($urandom), $urandom_range(31, 1), $urandom_range(3, 0),
                $urandom_range(15, 0), 1'($urandom), 1'($urandom), 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule